// File: doc/BRIEF.md
# Reset Controller with Cause Status

This block merges four reset sources into one active-high system reset and records which sources have fired. The sources are an external active-low hardware reset, a software request made through a register write, a watchdog request and a sleep-exit request. The watchdog and sleep requests arrive as single-cycle strobes from logic outside this block.

Software uses a 32-bit register port with a byte address, a write strobe, write data and combinational read data. Offset 0x0 holds a trigger that is only written. Setting its bit 0 arms a software reset, which fires after a fixed delay, and the trigger then clears itself. Offset 0x4 holds a cause register. Its bits stay set until software clears them by writing ones.

The hardware reset leaves the cause register with only the hardware bit set. The other three sources add their own bit and leave the rest unchanged, so causes build up until software clears them. The controller's own state is reset only by the hardware input, so the record survives every reset the block issues itself.

Top module: `rcc_top`

## Requirements
- R1: While `hw_rst_n` is low, `sys_rst` is 1. After `hw_rst_n` goes high, the cause register at 0x4 reads 0x1 and no software request is pending.
- R2: A write to offset 0x0 with bit 0 = 1 arms a software reset. The request is applied at the 4th rising edge after the write edge, and `sys_rst` goes high right after that edge. A write there with bit 0 = 0 has no effect.
- R3: Each software, watchdog (`wdog_req`) or sleep (`sleep_req`) event holds `sys_rst` high for exactly 8 clock cycles, counted from the edge that samples the event.
- R4: The cause register layout is bit 0 hardware, bit 1 software, bit 2 watchdog, bit 3 sleep. Each bit is set by its own source at the edge the event is sampled.
- R5: Writing 1 to a cause bit at 0x4 clears that bit at the write edge. Writing 0 leaves the bit unchanged.
- R6: If a cause event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R7: A software, watchdog or sleep reset never clears cause bits, so several causes can be set at once.
- R8: Reads of 0x0 and of unmapped offsets return 0. Bits 31..4 of the cause register read 0, and writes to them are ignored.
- R9: An event that arrives while `sys_rst` is already held restarts the full 8-cycle count.
- R10: A trigger write made while a software request is pending is ignored and does not produce a second reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | External hardware reset, active low, asynchronous |
| wdog_req | input | 1 | Watchdog reset strobe, one cycle |
| sleep_req | input | 1 | Sleep-exit reset strobe, one cycle |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sys_rst | output | 1 | System reset output, active high |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a clearing write to the cause register and a source event on the same bit. The bench raises `wdog_req` in the same cycle as a write of 0xF to 0x4, and expects bit 2 to stay set while the other bits clear. The second pair is a new event arriving while `sys_rst` is still being held from an earlier one. The bench starts a sleep request three cycles into a watchdog pulse and expects `sys_rst` to stay high for eight cycles after the second event, rather than ending on the first event's schedule. A behavioural model in the bench judges both cases by comparing every cycle.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned NUM_CAUSES = 4;

   typedef enum int unsigned {
      CAUSE_HW    = 0,
      CAUSE_SW    = 1,
      CAUSE_WDOG  = 2,
      CAUSE_SLEEP = 3
   } cause_e;
endpackage

// File: rtl/rcc_swtrig.sv
// Software request: arms on a write, fires after DELAY edges, then clears itself.
module rcc_swtrig #(
   parameter int unsigned DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic fire_o,
   output logic busy_o
);
   localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic          pend;
   logic [CW-1:0] cnt;

   initial begin
      assert (DELAY >= 1) else $error("rcc_swtrig: DELAY must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (pend) begin
         if (cnt == LAST) begin
            pend <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end else if (req_i) begin
         pend <= 1'b1;
         cnt  <= '0;
      end
   end

   assign fire_o = pend && (cnt == LAST);
   assign busy_o = pend;

   // R2: the request clears itself once it has fired
   a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !pend);
   // R10: a pending request keeps counting and is not restarted by new writes
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && cnt != LAST) |=> (pend && cnt == CW'($past(cnt) + CW'(1))));
endmodule

// File: rtl/rcc_cause_reg.sv
// Sticky cause bits: set by the sources, cleared by writing one, set wins.
module rcc_cause_reg
   import rcc_pkg::*;
#(
   parameter int unsigned N = NUM_CAUSES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   initial begin
      assert (N > int'(CAUSE_SLEEP)) else $error("rcc_cause_reg: N too small for all causes");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == int'(CAUSE_HW)) begin : g_hw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q_o[i] <= 1'b1;
            else if (set_i[i])   q_o[i] <= 1'b1;
            else if (clr_i[i])   q_o[i] <= 1'b0;
         end
      end else begin : g_other
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q_o[i] <= 1'b0;
            else if (set_i[i])   q_o[i] <= 1'b1;
            else if (clr_i[i])   q_o[i] <= 1'b0;
         end
      end

      // R6: a set beats a clear at the same edge
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);
      // R5: with no set and no clear the bit holds
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !clr_i[i]) |=> $stable(q_o[i]));
      // R5: a clear with no set empties the bit
      a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);
   end
endmodule

// File: rtl/rcc_pulse.sv
// Reset stretcher: any trigger (re)loads a LEN-cycle window.
module rcc_pulse #(
   parameter int unsigned LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic active_o
);
   localparam int unsigned CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(LEN);

   logic [CW-1:0] cnt;

   initial begin
      assert (LEN >= 1) else $error("rcc_pulse: LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (trig_i)      cnt <= FULL;
      else if (cnt != '0)   cnt <= cnt - CW'(1);
   end

   assign active_o = (cnt != '0);

   // R3 / R9: every trigger gives a full window
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> (cnt == FULL));
   // R3: the window shrinks one step per cycle
   a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_i && cnt != '0) |=> (cnt == CW'($past(cnt) - CW'(1))));
endmodule

// File: rtl/rcc_top.sv
module rcc_top
   import rcc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SW_DELAY  = 4,
   parameter int unsigned PULSE_LEN = 8,
   parameter int unsigned TRIG_OFS  = 'h0,
   parameter int unsigned CAUSE_OFS = 'h4
) (
   input  logic              clk,
   input  logic              hw_rst_n,
   input  logic              wdog_req,
   input  logic              sleep_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sys_rst
);
   localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(TRIG_OFS);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFS);

   initial begin
      assert (TRIG_OFS != CAUSE_OFS) else $error("rcc_top: register offsets collide");
      assert (CAUSE_OFS < (1 << ADDR_W)) else $error("rcc_top: ADDR_W too small");
   end

   logic                  hit_trig, hit_cause;
   logic                  sw_fire, sw_busy;
   logic [NUM_CAUSES-1:0] cause_set, cause_clr, cause_q;
   logic                  any_event, pulse_on;
   logic                  unused_wdata;

   assign hit_trig  = bus_we && (bus_addr == A_TRIG);
   assign hit_cause = bus_we && (bus_addr == A_CAUSE);

   rcc_swtrig #(.DELAY(SW_DELAY)) u_swtrig (
      .clk    (clk),
      .rst_n  (hw_rst_n),
      .req_i  (hit_trig && bus_wdata[0]),
      .fire_o (sw_fire),
      .busy_o (sw_busy)
   );

   always_comb begin
      cause_set                    = '0;
      cause_set[int'(CAUSE_SW)]    = sw_fire;
      cause_set[int'(CAUSE_WDOG)]  = wdog_req;
      cause_set[int'(CAUSE_SLEEP)] = sleep_req;
      cause_clr = hit_cause ? bus_wdata[NUM_CAUSES-1:0] : '0;
   end

   rcc_cause_reg #(.N(NUM_CAUSES)) u_cause (
      .clk   (clk),
      .rst_n (hw_rst_n),
      .set_i (cause_set),
      .clr_i (cause_clr),
      .q_o   (cause_q)
   );

   assign any_event = sw_fire | wdog_req | sleep_req;

   rcc_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk      (clk),
      .rst_n    (hw_rst_n),
      .trig_i   (any_event),
      .active_o (pulse_on)
   );

   assign sys_rst = !hw_rst_n || pulse_on;

   always_comb begin
      if (bus_addr == A_CAUSE) bus_rdata = {{(DATA_W-NUM_CAUSES){1'b0}}, cause_q};
      else                     bus_rdata = '0;
   end

   assign unused_wdata = ^bus_wdata[31:1] ^ sw_busy;

   // R8: reserved bits always read zero
   always_comb begin
      a_r8_reserved_zero: assert (bus_rdata[31:NUM_CAUSES] == '0);
   end
   // R1: the output follows the hardware reset input
   always_comb begin
      if (!hw_rst_n) a_r1_hw_drives_out: assert (sys_rst);
   end
   // R4 / R7: a watchdog event sets its bit and keeps the others
   a_r7_accumulate: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (wdog_req && !hit_cause) |=> (cause_q[int'(CAUSE_WDOG)] &&
                                   ((cause_q & $past(cause_q)) == $past(cause_q))));
   // R3: an event always produces the system reset on the next cycle
   a_r3_event_resets: assert property (@(posedge clk) disable iff (!hw_rst_n)
      any_event |=> sys_rst);
endmodule

// File: tb/rcc_top_test.sv
module rcc_top_test;
   logic        clk = 1'b0;
   logic        hw_rst_n = 1'b0;
   logic        wdog_req = 1'b0;
   logic        sleep_req = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        sys_rst;

   int    checks = 0;
   int    fails  = 0;
   string phase  = "R1";
   int    cycles = 0;
   bit    done   = 0;

   // reference model state
   int m_status = 1;
   int m_left   = 0;
   int m_pulse  = 0;

   rcc_top uut (
      .clk(clk), .hw_rst_n(hw_rst_n), .wdog_req(wdog_req), .sleep_req(sleep_req),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sys_rst(sys_rst)
   );

   always #4 clk = ~clk;

   always @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n) begin
         m_status = 1; m_left = 0; m_pulse = 0;
      end else begin
         bit fire;
         bit ev;
         fire = (m_left == 1);
         if (m_left > 0) m_left = m_left - 1;
         else if (bus_we && bus_addr == 8'h00 && bus_wdata[0]) m_left = 4;
         ev = fire || wdog_req || sleep_req;
         if (bus_we && bus_addr == 8'h04) m_status = m_status & ~int'(bus_wdata[3:0]);
         if (fire)      m_status = m_status | 2;
         if (wdog_req)  m_status = m_status | 4;
         if (sleep_req) m_status = m_status | 8;
         if (ev) m_pulse = 8;
         else if (m_pulse > 0) m_pulse = m_pulse - 1;
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at t=%0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         check({phase, " sys_rst"}, {31'b0, sys_rst}, {31'b0, (!hw_rst_n || m_pulse > 0)});
         check({phase, " rdata"}, bus_rdata, (bus_addr == 8'h04) ? m_status : 32'h0);
      end
   end

   task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic wd, input logic sl);
      @(posedge clk); #1;
      bus_we = we; bus_addr = a; bus_wdata = d; wdog_req = wd; sleep_req = sl;
   endtask

   task automatic idle(input int n, input logic [7:0] a);
      for (int i = 0; i < n; i++) drive(1'b0, a, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
   end

   initial begin
      // R1: hardware reset held, then released
      phase = "R1";
      idle(3, 8'h04);
      drive(1'b0, 8'h04, 0, 0, 0); hw_rst_n = 1'b1;
      idle(2, 8'h04);
      @(negedge clk); check("R1 cause after hw reset", bus_rdata, 32'h1);
      // R8: trigger and unmapped offsets read zero
      phase = "R8"; idle(1, 8'h00); idle(1, 8'h08);
      // R5: write one clears, write zero keeps
      phase = "R5";
      drive(1'b1, 8'h04, 32'h0, 0, 0); idle(1, 8'h04);
      drive(1'b1, 8'h04, 32'h1, 0, 0); idle(2, 8'h04);
      @(negedge clk); check("R5 hw bit cleared", bus_rdata, 32'h0);
      // R2: zero write does nothing, one write arms
      phase = "R2";
      drive(1'b1, 8'h00, 32'hFFFF_FFFE, 0, 0); idle(6, 8'h04);
      drive(1'b1, 8'h00, 32'h1, 0, 0);
      phase = "R3"; idle(14, 8'h04);
      @(negedge clk); check("R4 software bit", bus_rdata, 32'h2);
      // R10: second trigger while pending is ignored
      phase = "R10";
      drive(1'b1, 8'h00, 32'h1, 0, 0); idle(1, 8'h04);
      drive(1'b1, 8'h00, 32'h1, 0, 0); idle(16, 8'h04);
      // R4 / R7: watchdog and sleep accumulate
      phase = "R7";
      drive(1'b0, 8'h04, 0, 1, 0); idle(10, 8'h04);
      drive(1'b0, 8'h04, 0, 0, 1); idle(10, 8'h04);
      @(negedge clk); check("R7 accumulated causes", bus_rdata, 32'hE);
      // R9: new event during a held reset restarts the count
      phase = "R9";
      drive(1'b0, 8'h04, 0, 1, 0); idle(3, 8'h04);
      drive(1'b0, 8'h04, 0, 0, 1); idle(12, 8'h04);
      // R6: set beats clear in the same cycle
      phase = "R6";
      drive(1'b1, 8'h04, 32'hF, 1, 0); idle(2, 8'h04);
      @(negedge clk); check("R6 set wins", bus_rdata, 32'h4);
      idle(10, 8'h04);
      // R8: reserved bits ignore writes
      phase = "R8";
      drive(1'b1, 8'h04, 32'hFFFF_FFF0, 0, 0); idle(2, 8'h04);
      @(negedge clk); check("R8 reserved write ignored", bus_rdata, 32'h4);
      idle(2, 8'h08);
      // R1: hardware reset in the middle of a pulse
      phase = "R1";
      drive(1'b0, 8'h04, 0, 0, 1); idle(2, 8'h04);
      @(posedge clk); #1 hw_rst_n = 1'b0;
      idle(2, 8'h04);
      @(posedge clk); #1 hw_rst_n = 1'b1;
      idle(3, 8'h04);
      @(negedge clk); check("R1 cause after second hw reset", bus_rdata, 32'h1);
      idle(2, 8'h04);
      finish_run();
   end
endmodule